// File: doc/BRIEF.md
# Translation Cache with Selective Flush

This block is a small fully associative store of page translations. A lookup presents a logical page number, which is bits 31:12 of a 32-bit logical address with 4 KiB pages. One clock later the block returns a hit flag, the physical page number and a write-protect bit. Each resident entry also carries a global flag. Invalidations can skip entries that have this flag set, so mappings shared by every address space survive a context switch.

A single command port carries fills, four kinds of flush and a probe. A probe takes a logical page together with a translation produced elsewhere, for example by a table walker. It reports a three-bit summary in a status register and installs the translation when it is valid. Page-table walking, permission checks and memory access live outside this block.

The command controller has two states. In `ST_READY` it accepts commands. A probe moves it to `ST_INSTALL` (transition *probe accepted*). In `ST_INSTALL` the entry is written and the status register is updated, and the controller always returns to `ST_READY` on the next edge (transition *install done*). All other commands leave it in `ST_READY`.

Top module: `xlat_cache`

## Requirements
- R1: When `lk_req` is high at a clock edge, then after that edge `lk_hit` is 1 and `lk_ppn`/`lk_wp` show the entry whose tag equals `lk_vpn`. On a miss, or when `lk_req` was low, `lk_hit` is 0.
- R2: A command is accepted at an edge where `cmd_valid` and `cmd_ready` are both high. Code 0 (fill) writes `cmd_vpn`, `xl_ppn`, `xl_wp` and `xl_glb` at that edge. If the tag is already resident, that same entry is overwritten, so no two valid entries ever share a tag.
- R3: Code 1 invalidates every entry, global ones included.
- R4: Code 2 invalidates every entry whose global flag is 0. Global entries stay valid.
- R5: Code 3 invalidates the entry whose tag equals `cmd_vpn`, whatever its global flag. Other entries are untouched.
- R6: Code 4 invalidates the entry whose tag equals `cmd_vpn` only if its global flag is 0.
- R7: Code 5 (probe) is accepted at edge k. During the next cycle `cmd_ready` is 0. At edge k+1 the status outputs take: `st_hit` = the tag was resident when the probe was presented; `st_wp` = `xl_ok & xl_wp`; `st_inv` = `!xl_ok`. At the same edge the translation is installed if `xl_ok` was 1, and dropped otherwise.
- R8: A new entry goes to the lowest-numbered invalid slot. When all slots are valid it goes to a round-robin pointer that starts at 0 after reset and advances by one each time it is used. Overwriting a resident tag does not move the pointer.
- R9: A flush and a lookup in the same cycle are ordered flush first: the lookup reports a miss for any entry that the flush removes.
- R10: Codes 6 and 7 have no effect. Any command presented while `cmd_ready` is 0 is ignored.
- R11: After reset no entry is valid, `cmd_ready` is 1, and `lk_hit`, `st_hit`, `st_wp` and `st_inv` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (0 fill, 1 flush all, 2 flush non-global, 3 flush page, 4 flush page non-global, 5 probe) |
| cmd_vpn | input | 20 | Logical page number for the command |
| xl_ok | input | 1 | Supplied translation is valid (probe) |
| xl_ppn | input | 20 | Supplied physical page number |
| xl_wp | input | 1 | Supplied write-protect bit |
| xl_glb | input | 1 | Supplied global flag |
| cmd_ready | output | 1 | Controller can accept a command |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Logical page number to look up |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_ppn | output | 20 | Physical page number of the hit |
| lk_wp | output | 1 | Write-protect bit of the hit |
| st_hit | output | 1 | Status: probed page was resident |
| st_wp | output | 1 | Status: probed page is write-protected |
| st_inv | output | 1 | Status: probed translation was invalid |

## Verification
The bench goes after the global flag in each selective flush. A design that ignored the flag would drop shared mappings on a non-global flush, and one that always honoured it would leave global pages behind on a full or by-page flush. It checks flush and lookup in the same cycle, where a design ordered the wrong way would return a stale hit. It refills a full cache and then a partly flushed one. Blind round-robin replacement would evict a surviving global entry, and a broken pointer would evict the wrong page. It also checks a re-fill of a resident tag, which would otherwise leave duplicates or advance the pointer. Probes are run with a resident page, a valid new page and an invalid translation, with a stray command issued during the busy cycle. This catches a wrong status bit, installation of a bad translation, or a command accepted while busy.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Command codes as seen on cmd_op.
    typedef enum logic [2:0] {
        OP_FILL     = 3'd0,
        OP_FL_ALL   = 3'd1,
        OP_FL_NG    = 3'd2,
        OP_FL_PG    = 3'd3,
        OP_FL_PG_NG = 3'd4,
        OP_PROBE    = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } xlat_op_e;

    // Controller states.
    typedef enum logic {
        ST_READY   = 1'b0,
        ST_INSTALL = 1'b1
    } xlat_state_e;

endpackage

// File: rtl/xlat_store.sv
module xlat_store #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [TAG_W-1:0]   cmd_tag,
    input  logic               kill_en,
    input  logic               kill_by_tag,
    input  logic               kill_ng_only,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               wr_wp,
    input  logic               wr_glb,
    output logic [ENTRIES-1:0] vld_o,
    output logic               cmd_hit,
    output logic [IDX_W-1:0]   cmd_hit_idx,
    output logic               lk_hit_q,
    output logic [PPN_W-1:0]   lk_ppn_q,
    output logic               lk_wp_q
);

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] wp_q;
    logic [ENTRIES-1:0] glb_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];

    logic [ENTRIES-1:0] cmd_m;
    logic [ENTRIES-1:0] kill;
    logic [ENTRIES-1:0] lk_m;

    logic               lk_any;
    logic [PPN_W-1:0]   lk_ppn_d;
    logic               lk_wp_d;

    // Per-entry comparators and flush qualification.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign cmd_m[g] = vld[g] && (tag_q[g] == cmd_tag);
        assign kill[g]  = kill_en
                       && (!kill_by_tag  || cmd_m[g])
                       && (!kill_ng_only || !glb_q[g]);
        // Lookup sees the state after any flush of this cycle.
        assign lk_m[g]  = vld[g] && !kill[g] && (tag_q[g] == lk_tag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    vld[i] <= 1'b1;
                end else if (kill[i]) begin
                    vld[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            ppn_q[wr_idx] <= wr_ppn;
            wp_q[wr_idx]  <= wr_wp;
            glb_q[wr_idx] <= wr_glb;
        end
    end

    // Lowest matching slot for the command tag (at most one can match).
    always_comb begin
        cmd_hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cmd_m[i]) begin
                cmd_hit_idx = IDX_W'(i);
            end
        end
    end
    assign cmd_hit = |cmd_m;

    // One-hot OR mux of the lookup hit.
    always_comb begin
        lk_any   = 1'b0;
        lk_ppn_d = '0;
        lk_wp_d  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_m[i]) begin
                lk_any   = 1'b1;
                lk_ppn_d = lk_ppn_d | ppn_q[i];
                lk_wp_d  = lk_wp_d | wp_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_hit_q <= 1'b0;
            lk_ppn_q <= '0;
            lk_wp_q  <= 1'b0;
        end else begin
            lk_hit_q <= lk_req && lk_any;
            lk_ppn_q <= lk_ppn_d;
            lk_wp_q  <= lk_wp_d;
        end
    end

    assign vld_o = vld;

    // R2: tags stay unique among valid entries.
    a_r2_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_m));

    // R3: a full flush leaves nothing valid.
    a_r3_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_en && !kill_by_tag && !kill_ng_only) |=> (vld == '0));

    // R4: a non-global flush keeps every global entry.
    a_r4_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_en && kill_ng_only && !kill_by_tag)
        |=> ((vld & glb_q) == $past(vld & glb_q)));

    // R9: a flushed entry never produces a lookup hit in the flush cycle.
    a_r9_flush_before_look: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_m & kill) == '0);

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld,
    input  logic               take,
    output logic [IDX_W-1:0]   victim
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             all_full;

    assign all_full = &vld;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim = all_full ? rr_q : free_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (take && all_full) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    // R8: with room left, the chosen slot is an empty one.
    a_r8_pick_free: assert property (@(posedge clk) disable iff (!rst_n)
        !all_full |-> !vld[victim]);

    // R8: using the pointer moves it on.
    a_r8_rr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (take && all_full) |=> (rr_q != $past(rr_q)));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import xlat_pkg::*;
#(
    parameter int TAG_W = 20,
    parameter int PPN_W = 20,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic             xl_ok,
    input  logic [PPN_W-1:0] xl_ppn,
    input  logic             xl_wp,
    input  logic             xl_glb,
    input  logic             cmd_hit,
    input  logic [IDX_W-1:0] cmd_hit_idx,
    input  logic [IDX_W-1:0] victim,
    output logic             cmd_ready,
    output logic             kill_en,
    output logic             kill_by_tag,
    output logic             kill_ng_only,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [TAG_W-1:0] wr_tag,
    output logic [PPN_W-1:0] wr_ppn,
    output logic             wr_wp,
    output logic             wr_glb,
    output logic             take,
    output logic             st_hit,
    output logic             st_wp,
    output logic             st_inv
);

    xlat_state_e state, state_nx;
    xlat_op_e    op;

    logic [TAG_W-1:0] p_tag;
    logic [PPN_W-1:0] p_ppn;
    logic             p_wp;
    logic             p_glb;
    logic             p_ok;
    logic             p_hit;
    logic [IDX_W-1:0] p_idx;
    logic             probe_go;

    assign op       = xlat_op_e'(cmd_op);
    assign probe_go = (state == ST_READY) && cmd_valid && (op == OP_PROBE);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READY;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and datapath controls.
    always_comb begin
        state_nx     = state;
        cmd_ready    = 1'b0;
        kill_en      = 1'b0;
        kill_by_tag  = 1'b0;
        kill_ng_only = 1'b0;
        wr_en        = 1'b0;
        wr_idx       = victim;
        wr_tag       = cmd_tag;
        wr_ppn       = xl_ppn;
        wr_wp        = xl_wp;
        wr_glb       = xl_glb;
        take         = 1'b0;
        unique case (state)
            ST_READY: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    unique case (op)
                        OP_FILL: begin
                            wr_en  = 1'b1;
                            wr_idx = cmd_hit ? cmd_hit_idx : victim;
                            take   = !cmd_hit;
                        end
                        OP_FL_ALL: begin
                            kill_en = 1'b1;
                        end
                        OP_FL_NG: begin
                            kill_en      = 1'b1;
                            kill_ng_only = 1'b1;
                        end
                        OP_FL_PG: begin
                            kill_en     = 1'b1;
                            kill_by_tag = 1'b1;
                        end
                        OP_FL_PG_NG: begin
                            kill_en      = 1'b1;
                            kill_by_tag  = 1'b1;
                            kill_ng_only = 1'b1;
                        end
                        OP_PROBE: begin
                            state_nx = ST_INSTALL;
                        end
                        OP_RSV6, OP_RSV7: begin
                        end
                    endcase
                end
            end
            ST_INSTALL: begin
                state_nx = ST_READY;
                wr_en    = p_ok;
                wr_idx   = p_hit ? p_idx : victim;
                wr_tag   = p_tag;
                wr_ppn   = p_ppn;
                wr_wp    = p_wp;
                wr_glb   = p_glb;
                take     = p_ok && !p_hit;
            end
        endcase
    end

    // Probe capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_tag <= '0;
            p_ppn <= '0;
            p_wp  <= 1'b0;
            p_glb <= 1'b0;
            p_ok  <= 1'b0;
            p_hit <= 1'b0;
            p_idx <= '0;
        end else if (probe_go) begin
            p_tag <= cmd_tag;
            p_ppn <= xl_ppn;
            p_wp  <= xl_wp;
            p_glb <= xl_glb;
            p_ok  <= xl_ok;
            p_hit <= cmd_hit;
            p_idx <= cmd_hit_idx;
        end
    end

    // Status register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_hit <= 1'b0;
            st_wp  <= 1'b0;
            st_inv <= 1'b0;
        end else if (state == ST_INSTALL) begin
            st_hit <= p_hit;
            st_wp  <= p_ok && p_wp;
            st_inv <= !p_ok;
        end
    end

    // R7: install lasts exactly one cycle.
    a_r7_install_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSTALL) |=> (state == ST_READY));

    // R7: an accepted probe blocks the next cycle.
    a_r7_probe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (op == OP_PROBE)) |=> !cmd_ready);

    // R7: an invalid translation never reports write protection.
    a_r7_inv_no_wp: assert property (@(posedge clk) disable iff (!rst_n)
        st_inv |-> !st_wp);

    // R10: no flush while busy.
    a_r10_no_kill_busy: assert property (@(posedge clk) disable iff (!rst_n)
        kill_en |-> cmd_ready);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int ENTRIES   = 8,
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PPN_W     = 20,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [VPN_W-1:0] cmd_vpn,
    input  logic             xl_ok,
    input  logic [PPN_W-1:0] xl_ppn,
    input  logic             xl_wp,
    input  logic             xl_glb,
    output logic             cmd_ready,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wp,
    output logic             st_hit,
    output logic             st_wp,
    output logic             st_inv
);

    logic [ENTRIES-1:0] vld;
    logic               cmd_hit;
    logic [IDX_W-1:0]   cmd_hit_idx;
    logic [IDX_W-1:0]   victim;
    logic               kill_en, kill_by_tag, kill_ng_only;
    logic               wr_en, wr_wp, wr_glb, take;
    logic [IDX_W-1:0]   wr_idx;
    logic [VPN_W-1:0]   wr_tag;
    logic [PPN_W-1:0]   wr_ppn;

    xlat_ctrl #(
        .TAG_W (VPN_W),
        .PPN_W (PPN_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_tag      (cmd_vpn),
        .xl_ok        (xl_ok),
        .xl_ppn       (xl_ppn),
        .xl_wp        (xl_wp),
        .xl_glb       (xl_glb),
        .cmd_hit      (cmd_hit),
        .cmd_hit_idx  (cmd_hit_idx),
        .victim       (victim),
        .cmd_ready    (cmd_ready),
        .kill_en      (kill_en),
        .kill_by_tag  (kill_by_tag),
        .kill_ng_only (kill_ng_only),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_ppn       (wr_ppn),
        .wr_wp        (wr_wp),
        .wr_glb       (wr_glb),
        .take         (take),
        .st_hit       (st_hit),
        .st_wp        (st_wp),
        .st_inv       (st_inv)
    );

    xlat_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_req       (lk_req),
        .lk_tag       (lk_vpn),
        .cmd_tag      (cmd_vpn),
        .kill_en      (kill_en),
        .kill_by_tag  (kill_by_tag),
        .kill_ng_only (kill_ng_only),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_ppn       (wr_ppn),
        .wr_wp        (wr_wp),
        .wr_glb       (wr_glb),
        .vld_o        (vld),
        .cmd_hit      (cmd_hit),
        .cmd_hit_idx  (cmd_hit_idx),
        .lk_hit_q     (lk_hit),
        .lk_ppn_q     (lk_ppn),
        .lk_wp_q      (lk_wp)
    );

    xlat_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (vld),
        .take   (take),
        .victim (victim)
    );

    // R1: no request, no hit on the following cycle.
    a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_hit);

endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [19:0] cmd_vpn = '0;
    logic        xl_ok = 1'b0;
    logic [19:0] xl_ppn = '0;
    logic        xl_wp = 1'b0;
    logic        xl_glb = 1'b0;
    logic        cmd_ready;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        lk_wp;
    logic        st_hit, st_wp, st_inv;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vpn(cmd_vpn), .xl_ok(xl_ok), .xl_ppn(xl_ppn), .xl_wp(xl_wp),
        .xl_glb(xl_glb), .cmd_ready(cmd_ready), .lk_req(lk_req),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_wp(lk_wp),
        .st_hit(st_hit), .st_wp(st_wp), .st_inv(st_inv)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic        hit;
        logic [19:0] ppn;
        logic        wp;
        logic [19:0] vpn;
        string       req;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;
    logic issued = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, pushes the expected lookup result.
    task automatic drive(input bit cv, input logic [2:0] op, input logic [19:0] cvpn,
                         input bit ok, input logic [19:0] ppn, input bit wp, input bit glb,
                         input bit lr, input logic [19:0] lvpn,
                         input bit ehit, input logic [19:0] eppn, input bit ewp,
                         input string req);
        exp_t e;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_vpn = cvpn;
        xl_ok = ok; xl_ppn = ppn; xl_wp = wp; xl_glb = glb;
        lk_req = lr; lk_vpn = lvpn;
        if (lr) begin
            e.hit = ehit; e.ppn = eppn; e.wp = ewp; e.vpn = lvpn; e.req = req;
            q.push_back(e);
        end
    endtask

    task automatic idle();
        drive(0, 3'd0, '0, 0, '0, 0, 0, 0, '0, 0, '0, 0, "");
    endtask

    task automatic cmd(input logic [2:0] op, input logic [19:0] vpn, input bit ok,
                       input logic [19:0] ppn, input bit wp, input bit glb);
        drive(1, op, vpn, ok, ppn, wp, glb, 0, '0, 0, '0, 0, "");
    endtask

    task automatic look(input logic [19:0] vpn, input bit ehit,
                        input logic [19:0] eppn, input bit ewp, input string req);
        drive(0, 3'd0, '0, 0, '0, 0, 0, 1, vpn, ehit, eppn, ewp, req);
    endtask

    task automatic cmd_look(input logic [2:0] op, input logic [19:0] cvpn,
                            input logic [19:0] lvpn, input bit ehit,
                            input logic [19:0] eppn, input bit ewp, input string req);
        drive(1, op, cvpn, 0, '0, 0, 0, 1, lvpn, ehit, eppn, ewp, req);
    endtask

    task automatic check_status(input bit h, input bit w, input bit i);
        check(st_hit === h, "R7", "st_hit", 32'(st_hit), 32'(h));
        check(st_wp === w,  "R7", "st_wp",  32'(st_wp),  32'(w));
        check(st_inv === i, "R7", "st_inv", 32'(st_inv), 32'(i));
    endtask

    // Monitor: compares each lookup result one cycle after its request.
    always @(posedge clk) issued <= lk_req;

    always @(negedge clk) begin
        if (issued && q.size() != 0) begin
            mon_e = q.pop_front();
            check(lk_hit === mon_e.hit, mon_e.req, $sformatf("hit vpn=%h", mon_e.vpn),
                  32'(lk_hit), 32'(mon_e.hit));
            if (mon_e.hit) begin
                check(lk_ppn === mon_e.ppn, mon_e.req, "ppn", 32'(lk_ppn), 32'(mon_e.ppn));
                check(lk_wp === mon_e.wp, mon_e.req, "wp", 32'(lk_wp), 32'(mon_e.wp));
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(cmd_ready === 1'b1, "R11", "cmd_ready", 32'(cmd_ready), 32'd1);
        check(lk_hit === 1'b0, "R11", "lk_hit", 32'(lk_hit), 32'd0);
        check({st_hit, st_wp, st_inv} === 3'b000, "R11", "status",
              32'({st_hit, st_wp, st_inv}), 32'd0);
        look(20'h10000, 0, '0, 0, "R11");

        // R2: fill all eight slots; globals at 0, 3, 6
        for (int i = 0; i < 8; i++) begin
            cmd(3'd0, 20'h10000 + 20'(i), 1, 20'hA0000 + 20'(i), i[0],
                (i == 0) || (i == 3) || (i == 6));
        end
        for (int i = 0; i < 8; i++) begin
            look(20'h10000 + 20'(i), 1, 20'hA0000 + 20'(i), i[0], "R1");
        end

        // R2: refill a resident tag overwrites in place
        cmd(3'd0, 20'h10002, 1, 20'hBBBBB, 1, 0);
        look(20'h10002, 1, 20'hBBBBB, 1, "R2");
        look(20'h10000, 1, 20'hA0000, 0, "R2");

        // R8: full cache, round-robin from slot 0, then slot 1
        cmd(3'd0, 20'h20000, 1, 20'h20000, 0, 0);
        look(20'h10000, 0, '0, 0, "R8");
        look(20'h20000, 1, 20'h20000, 0, "R8");
        look(20'h10001, 1, 20'hA0001, 1, "R8");
        cmd(3'd0, 20'h20001, 1, 20'h20001, 0, 0);
        look(20'h10001, 0, '0, 0, "R8");
        look(20'h20001, 1, 20'h20001, 0, "R8");

        // R6: page non-global flush spares a global page, removes a non-global one
        cmd(3'd4, 20'h10003, 0, '0, 0, 0);
        look(20'h10003, 1, 20'hA0003, 1, "R6");
        cmd_look(3'd4, 20'h10004, 20'h10004, 0, '0, 0, "R9");
        look(20'h10004, 0, '0, 0, "R6");
        look(20'h10005, 1, 20'hA0005, 1, "R6");

        // R5: page flush removes a global page, leaves the rest
        cmd_look(3'd3, 20'h10003, 20'h10005, 1, 20'hA0005, 1, "R5");
        look(20'h10003, 0, '0, 0, "R5");

        // R10: reserved codes do nothing
        cmd(3'd6, 20'h10005, 1, 20'h11111, 0, 0);
        cmd(3'd7, 20'h10005, 1, 20'h22222, 0, 0);
        look(20'h10005, 1, 20'hA0005, 1, "R10");

        // R4: non-global flush keeps only globals
        cmd(3'd2, 20'h0, 0, '0, 0, 0);
        look(20'h10006, 1, 20'hA0006, 0, "R4");
        look(20'h20000, 0, '0, 0, "R4");
        look(20'h10007, 0, '0, 0, "R4");
        look(20'h10002, 0, '0, 0, "R4");

        // R8: refill free slots first; the lone global survives
        for (int j = 0; j < 7; j++) begin
            cmd(3'd0, 20'h30000 + 20'(j), 1, 20'h30000 + 20'(j), 0, 0);
        end
        look(20'h10006, 1, 20'hA0006, 0, "R8");
        for (int j = 0; j < 7; j++) begin
            look(20'h30000 + 20'(j), 1, 20'h30000 + 20'(j), 0, "R8");
        end

        // R7: probe of a resident page, with a flush presented while busy
        cmd(3'd5, 20'h30000, 1, 20'hCCCCC, 1, 0);
        cmd(3'd1, 20'h0, 0, '0, 0, 0);
        check(cmd_ready === 1'b0, "R7", "cmd_ready busy", 32'(cmd_ready), 32'd0);
        look(20'h10006, 1, 20'hA0006, 0, "R10");
        check_status(1, 1, 0);
        look(20'h30000, 1, 20'hCCCCC, 1, "R7");

        // R7: invalid translation is reported and not installed
        cmd(3'd5, 20'h40000, 0, 20'h44444, 1, 0);
        idle();
        idle();
        check_status(0, 0, 1);
        look(20'h40000, 0, '0, 0, "R7");

        // R7: valid new translation is installed
        cmd(3'd5, 20'h40001, 1, 20'hDDDDD, 0, 1);
        idle();
        idle();
        check_status(0, 0, 0);
        look(20'h40001, 1, 20'hDDDDD, 0, "R7");

        // R3 and R9: full flush, including globals, seen by same-cycle lookup
        cmd_look(3'd1, 20'h0, 20'h40001, 0, '0, 0, "R9");
        look(20'h10006, 0, '0, 0, "R3");
        look(20'h30001, 0, '0, 0, "R3");
        look(20'h40001, 0, '0, 0, "R3");

        idle();
        idle();
        idle();
        finish_run();
    end

endmodule